// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port

This block moves one byte at a time over a clocked serial link. It can act as master or as slave. As master it makes the serial clock from the system clock at one of three rates. As slave it follows a serial clock from outside, and that clock is brought into the system clock domain through a two-flop synchronizer. Software sets up the port and starts a transfer through a small write port. A Start bit permits exactly eight serial clock periods of shifting. After the last falling serial edge, Start clears itself and a completion flag is raised. The flag drives a maskable interrupt output.

One register is both the transmit and the receive register. Before a transfer it holds the byte to send. After the transfer it holds the byte received. The bit order and the sampling edge can be chosen. The transmit pin has two drive options. In direct mode it shows the outgoing bit straight from the shift register. In re-synchronized mode the bit is retimed to the rising serial clock edge. A select/ready output shows Start OR a software status bit. The parallel output mode only releases the serial pins.

Top module: `sync_serial_port`

## Requirements
- R1: After reset all of the following are 0: Start, the completion flag, the data register, the control fields and the output mode, `sclk_o`, `sclk_oe`, `sdout_o`, `sdout_oe`, `sel_o` and `irq_o`.
- R2: Master mode is selected by control bit 2 at address 0. In master mode, rate bits 4:3 set the `sclk_o` half period to 1 system cycle (00), 2 cycles (01) or 4 cycles (10 and 11). A transfer produces exactly eight high pulses. `sclk_o` is low from the cycle after Start is low.
- R3: In slave mode, `sclk_i` has no effect while Start is low. After Start is set, the eight following edge pairs on `sclk_i` complete the transfer.
- R4: Start clears itself on the eighth falling serial edge, and the completion flag is set in the same cycle. `irq_o` equals the flag AND control bit 7.
- R5: The completion flag is cleared only by reset or by a write to address 0 with bit 0 set. A control write with bit 0 clear leaves the flag unchanged.
- R6: When control bit 5 is 1, incoming data is sampled on the rising serial edge. When it is 0, data is sampled on the falling serial edge.
- R7: When control bit 6 is 1, data moves MSB first: bit 7 is sent first and the first bit received ends in bit 7. When it is 0, data moves LSB first.
- R8: Output mode 10 (address 1, bits 1:0) is direct mode. `sdout_o` shows the current outgoing bit from the moment Start is set, and it advances on each sampling edge.
- R9: Output mode 01 is re-synchronized mode. `sdout_o` is loaded with the current outgoing bit on each rising serial edge, whichever sampling edge is selected.
- R10: Output modes 00 and 11 drive neither `sdout_oe` nor `sclk_oe`. Modes 01 and 10 drive `sdout_oe`, and they also drive `sclk_oe` in master mode.
- R11: `sel_o` equals Start OR status (control bit 1).
- R12: A write to address 2 loads the data register only while Start is low. `rx_data_o` shows the data register, which holds the received byte after completion.
- R13: If a Start write falls in the completion cycle, the write takes precedence. A new transfer begins, the completion flag stays clear, and that transfer finishes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 output mode, 2 data |
| wr_data | input | BITS | Write value |
| sclk_i | input | 1 | Serial clock from outside (slave mode) |
| sdin_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| sdout_o | output | 1 | Serial data out |
| sdout_oe | output | 1 | Drive enable for the serial data pin |
| sel_o | output | 1 | Ready / chip select: Start OR status |
| irq_o | output | 1 | Masked completion interrupt |
| start_o | output | 1 | Current Start bit |
| rx_data_o | output | BITS | Data register contents |

## Verification
The collision that matters is between the eighth falling serial edge, which clears Start and raises the flag, and a software write that sets Start again. The bench runs a master transfer at the slowest rate and counts rising edges on `sclk_o`. It then times a control write to reach the port in the exact cycle of the final fall. The write is judged to have won if Start is still set, the flag is clear and the clock is low, and if the new transfer later ends with the flag raised. A second overlap is a data-register write during an active transfer. It must leave `rx_data_o` unchanged even when a shift edge could arrive in the same cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    OM_HIZ      = 2'b00,
    OM_RESYNC   = 2'b01,
    OM_DIRECT   = 2'b10,
    OM_PARALLEL = 2'b11
  } out_mode_e;

  // Bits 7:1 of the control word; bit 0 is Start and is held apart.
  typedef struct packed {
    logic       irq_en;
    logic       msb_first;
    logic       sample_rise;
    logic [1:0] rate;
    logic       master;
    logic       status;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [BITS-1:0] wr_data,
  input  logic            fall_ev,
  output ctrl_t           cfg,
  output out_mode_e       mode,
  output logic            start,
  output logic            start_load,
  output logic            irq_flag
);

  localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  ctrl_t            cfg_q, cfg_d;
  out_mode_e        mode_q, mode_d;
  logic             start_q, start_d;
  logic             irq_q, irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ctrl_wr, mode_wr, done;

  assign ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
  assign mode_wr    = wr_en && (wr_addr == ADDR_MODE);
  assign start_load = ctrl_wr && wr_data[0];
  assign done       = fall_ev && start_q && (cnt_q == LAST);

  always_comb begin
    cfg_d   = cfg_q;
    mode_d  = mode_q;
    start_d = start_q;
    irq_d   = irq_q;
    cnt_d   = cnt_q;
    if (mode_wr) mode_d = out_mode_e'(wr_data[1:0]);
    if (ctrl_wr) begin
      // a control write takes precedence over completion
      cfg_d   = ctrl_t'(wr_data[7:1]);
      start_d = wr_data[0];
      cnt_d   = '0;
      if (wr_data[0]) irq_d = 1'b0;
    end else if (done) begin
      start_d = 1'b0;
      irq_d   = 1'b1;
      cnt_d   = '0;
    end else if (fall_ev && start_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      mode_q  <= OM_HIZ;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cfg_q   <= cfg_d;
      mode_q  <= mode_d;
      start_q <= start_d;
      irq_q   <= irq_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cfg      = cfg_q;
  assign mode     = mode_q;
  assign start    = start_q;
  assign irq_flag = irq_q;

  assert_done_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_wr) |=> (irq_q && !start_q));
  assert_start_clears_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start_load |=> (start_q && !irq_q));
  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !start_load) |=> irq_q);

endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int SYNC_STAGES  = 2,
  parameter int RATE_LOG_MAX = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master,
  input  logic [1:0] rate,
  input  logic       start,
  input  logic       start_load,
  input  logic       sclk_i,
  input  logic       sdin_i,
  output logic       sclk_o,
  output logic       rise_ev,
  output logic       fall_ev,
  output logic       din
);

  localparam int CNT_W = (RATE_LOG_MAX > 0) ? RATE_LOG_MAX : 1;

  logic [CNT_W-1:0]       cnt_q, cnt_d, lim;
  logic                   sclk_q, sclk_d, tick, run;
  logic [SYNC_STAGES-1:0] ck_sync, dt_sync;
  logic                   ck_prev;
  logic                   s_ck, s_rise, s_fall;

  assign run = start && master;

  // half period of 2**rate cycles, codes above the maximum saturate
  always_comb begin
    if (int'(rate) > RATE_LOG_MAX) lim = CNT_W'((1 << RATE_LOG_MAX) - 1);
    else                           lim = CNT_W'((1 << rate) - 1);
  end

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    tick   = 1'b0;
    if (start_load || !run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (cnt_q == lim) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
      tick   = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      ck_sync <= '0;
      dt_sync <= '0;
      ck_prev <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sclk_q  <= sclk_d;
      ck_sync <= {ck_sync[SYNC_STAGES-2:0], sclk_i};
      dt_sync <= {dt_sync[SYNC_STAGES-2:0], sdin_i};
      ck_prev <= s_ck;
    end
  end

  assign s_ck   = ck_sync[SYNC_STAGES-1];
  assign s_rise = start && !master && s_ck && !ck_prev;
  assign s_fall = start && !master && !s_ck && ck_prev;

  assign rise_ev = master ? (tick && !sclk_q) : s_rise;
  assign fall_ev = master ? (tick &&  sclk_q) : s_fall;
  assign din     = master ? sdin_i : dt_sync[SYNC_STAGES-1];
  assign sclk_o  = sclk_q;

  assert_clock_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !$past(start)) |-> !sclk_q);

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sample_rise,
  input  logic            msb_first,
  input  logic            rise_ev,
  input  logic            fall_ev,
  input  logic            din,
  input  logic            data_wr,
  input  logic [BITS-1:0] wr_data,
  output logic [BITS-1:0] data_o,
  output logic            bit_direct,
  output logic            bit_resync
);

  logic [BITS-1:0] sr_q, sr_d;
  logic            rs_q, rs_d;
  logic            act, cur;

  assign act = start && (sample_rise ? rise_ev : fall_ev);
  assign cur = msb_first ? sr_q[BITS-1] : sr_q[0];

  always_comb begin
    sr_d = sr_q;
    rs_d = rs_q;
    if (data_wr && !start) begin
      sr_d = wr_data;
    end else if (act) begin
      if (msb_first) sr_d = {sr_q[BITS-2:0], din};
      else           sr_d = {din, sr_q[BITS-1:1]};
    end
    if (start && rise_ev) rs_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      rs_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      rs_q <= rs_d;
    end
  end

  assign data_o     = sr_q;
  assign bit_direct = cur;
  assign bit_resync = rs_q;

  assert_data_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && start && !act) |=> $stable(sr_q));
  assert_idle_ignores_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !data_wr) |=> $stable(sr_q));

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int BITS         = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int RATE_LOG_MAX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [BITS-1:0] wr_data,
  input  logic            sclk_i,
  input  logic            sdin_i,
  output logic            sclk_o,
  output logic            sclk_oe,
  output logic            sdout_o,
  output logic            sdout_oe,
  output logic            sel_o,
  output logic            irq_o,
  output logic            start_o,
  output logic [BITS-1:0] rx_data_o
);

  logic [1:0] rst_pipe;
  logic       rst_s_n;
  ctrl_t      cfg;
  out_mode_e  mode;
  logic       start, start_load, irq_flag;
  logic       rise_ev, fall_ev, din, sclk_int;
  logic       bit_direct, bit_resync, data_wr, pins_on;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign data_wr = wr_en && (wr_addr == ADDR_DATA);

  ssp_ctrl #(.BITS(BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fall_ev(fall_ev), .cfg(cfg), .mode(mode),
    .start(start), .start_load(start_load), .irq_flag(irq_flag)
  );

  ssp_clkgen #(.SYNC_STAGES(SYNC_STAGES), .RATE_LOG_MAX(RATE_LOG_MAX)) u_clk (
    .clk(clk), .rst_n(rst_s_n), .master(cfg.master), .rate(cfg.rate),
    .start(start), .start_load(start_load), .sclk_i(sclk_i), .sdin_i(sdin_i),
    .sclk_o(sclk_int), .rise_ev(rise_ev), .fall_ev(fall_ev), .din(din)
  );

  ssp_shifter #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_s_n), .start(start), .sample_rise(cfg.sample_rise),
    .msb_first(cfg.msb_first), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .din(din), .data_wr(data_wr), .wr_data(wr_data), .data_o(rx_data_o),
    .bit_direct(bit_direct), .bit_resync(bit_resync)
  );

  assign pins_on  = (mode == OM_RESYNC) || (mode == OM_DIRECT);
  assign sdout_oe = pins_on;
  assign sclk_oe  = pins_on && cfg.master;
  assign sclk_o   = sclk_int;
  always_comb begin
    case (mode)
      OM_RESYNC: sdout_o = bit_resync;
      OM_DIRECT: sdout_o = bit_direct;
      default:   sdout_o = 1'b0;
    endcase
  end

  assign sel_o   = start | cfg.status;
  assign irq_o   = irq_flag & cfg.irq_en;
  assign start_o = start;

  assert_pins_released_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == OM_HIZ || mode == OM_PARALLEL) |-> (!sdout_oe && !sclk_oe));

endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;

  logic       clk, rst_n, wr_en, sclk_i, sdin_i;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       sclk_o, sclk_oe, sdout_o, sdout_oe, sel_o, irq_o, start_o;
  logic [7:0] rx_data_o;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 0;

  sync_serial_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sclk_i(sclk_i), .sdin_i(sdin_i), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .sdout_o(sdout_o), .sdout_oe(sdout_oe), .sel_o(sel_o),
    .irq_o(irq_o), .start_o(start_o), .rx_data_o(rx_data_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cw(input bit st, input bit status, input bit mst,
                                    input logic [1:0] rate, input bit rise,
                                    input bit msb, input bit ien);
    return {ien, msb, rise, rate, mst, status, st};
  endfunction

  function automatic int half_of(input logic [1:0] rate);
    return (rate == 2'd0) ? 1 : (rate == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic bit_at(input logic [7:0] v, input bit msb, input int k);
    return msb ? v[7-k] : v[k];
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic master_xfer(input logic [1:0] rate, input bit rise, input bit msb,
                             input logic [1:0] om, input logic [7:0] tx,
                             input logic [7:0] rx, input bit ien);
    int k = 0, nf = 0, rises = 0, toggles = 0, gap = 0, gmin = 99, gmax = 0;
    logic prev_ck = 1'b0, prev_sd;
    logic [7:0] seq = '0, exp_seq;
    for (int i = 0; i < 8; i++) exp_seq[i] = bit_at(tx, msb, i);
    wr(2'd2, tx);
    wr(2'd1, {6'd0, om});
    sdin_i = bit_at(rx, msb, 0);
    wr(2'd0, cw(1, 0, 1, rate, rise, msb, ien));
    prev_sd = sdout_o;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      gap++;
      if (sclk_o != prev_ck) begin
        if (toggles > 0) begin
          if (gap < gmin) gmin = gap;
          if (gap > gmax) gmax = gap;
        end
        toggles++; gap = 0;
        if (sclk_o) rises++;
        if (sclk_o == rise) begin
          if (om == 2'b10 && k < 8) seq[k] = prev_sd;
          k++;
          if (k < 8) sdin_i = bit_at(rx, msb, k);
        end
        if (!sclk_o && om == 2'b01 && nf < 8) begin
          seq[nf] = sdout_o; nf++;
        end
      end
      prev_ck = sclk_o;
      prev_sd = sdout_o;
      if (!start_o) break;
    end
    chk(start_o == 1'b0, "R4 start self-clears", int'(start_o), 0);
    chk(irq_o == ien, "R4 irq masked by enable", int'(irq_o), int'(ien));
    chk(rises == 8, "R2 eight clock pulses", rises, 8);
    chk(gmin == half_of(rate) && gmax == half_of(rate), "R2 half period", gmax, half_of(rate));
    chk(rx_data_o == rx, "R6 R7 R12 received byte", int'(rx_data_o), int'(rx));
    if (om == 2'b10) chk(seq == exp_seq, "R8 R7 direct output order", int'(seq), int'(exp_seq));
    else             chk(seq == exp_seq, "R9 R7 resync output order", int'(seq), int'(exp_seq));
    @(negedge clk);
    chk(sclk_o == 1'b0, "R2 clock idle low", int'(sclk_o), 0);
  endtask

  task automatic slave_xfer(input bit rise, input bit msb, input logic [1:0] om,
                            input logic [7:0] tx, input logic [7:0] rx);
    wr(2'd2, tx);
    wr(2'd1, {6'd0, om});
    wr(2'd0, cw(0, 0, 0, 2'd0, rise, msb, 1));
    for (int p = 0; p < 3; p++) begin
      sdin_i = p[0];
      repeat (4) @(negedge clk); sclk_i = 1'b1;
      repeat (4) @(negedge clk); sclk_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk(rx_data_o == tx, "R3 slave clock ignored while idle", int'(rx_data_o), int'(tx));
    chk(start_o == 1'b0, "R3 no start while idle", int'(start_o), 0);
    wr(2'd0, cw(1, 0, 0, 2'd0, rise, msb, 1));
    chk(sel_o == 1'b1, "R11 select follows start", int'(sel_o), 1);
    chk(sclk_oe == 1'b0, "R10 slave leaves clock pin", int'(sclk_oe), 0);
    for (int k = 0; k < 8; k++) begin
      sdin_i = bit_at(rx, msb, k);
      repeat (4) @(negedge clk); sclk_i = 1'b1;
      repeat (4) @(negedge clk); sclk_i = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk(start_o == 1'b0, "R3 start clears after eight edges", int'(start_o), 0);
    chk(irq_o == 1'b1, "R4 slave completion irq", int'(irq_o), 1);
    chk(rx_data_o == rx, "R3 R6 R7 slave received byte", int'(rx_data_o), int'(rx));
  endtask

  initial begin
    logic [7:0] snap;
    int rcount;
    logic prev;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sclk_i = 1'b0; sdin_i = 1'b0;
    repeat (4) @(negedge clk);
    chk({sclk_o, sclk_oe, sdout_o, sdout_oe, sel_o, irq_o, start_o} == 7'd0,
        "R1 reset outputs", int'({sclk_o, sclk_oe, sdout_o, sdout_oe, sel_o, irq_o, start_o}), 0);
    chk(rx_data_o == 8'd0, "R1 reset data", int'(rx_data_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // output mode decode
    wr(2'd0, cw(0, 0, 1, 2'd0, 0, 0, 1));
    chk({sclk_oe, sdout_oe} == 2'b00, "R10 mode 00 released", int'({sclk_oe, sdout_oe}), 0);
    wr(2'd1, 8'd3);
    chk({sclk_oe, sdout_oe} == 2'b00, "R10 mode 11 released", int'({sclk_oe, sdout_oe}), 0);
    wr(2'd1, 8'd2);
    chk({sclk_oe, sdout_oe} == 2'b11, "R10 mode 10 drives", int'({sclk_oe, sdout_oe}), 3);

    // select pin
    wr(2'd0, cw(0, 1, 1, 2'd0, 0, 0, 1));
    chk(sel_o == 1'b1, "R11 status alone", int'(sel_o), 1);
    wr(2'd0, cw(0, 0, 1, 2'd0, 0, 0, 1));
    chk(sel_o == 1'b0, "R11 both low", int'(sel_o), 0);

    // directed corners: fastest and saturated rates, both edges and orders
    master_xfer(2'd0, 1, 1, 2'b10, 8'hA5, 8'h3C, 1);
    master_xfer(2'd3, 0, 0, 2'b01, 8'h81, 8'h7E, 1);

    // random master transfers
    for (int n = 0; n < 12; n++) begin
      logic [1:0] rt, om;
      rt = 2'($urandom_range(0, 3));
      om = $urandom_range(0, 1) ? 2'b10 : 2'b01;
      master_xfer(rt, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), om,
                  8'($urandom), 8'($urandom), 1);
    end

    // mask and flag lifetime
    master_xfer(2'd1, 1, 0, 2'b10, 8'h0F, 8'hF0, 0);
    wr(2'd0, cw(0, 0, 1, 2'd1, 1, 0, 1));
    chk(irq_o == 1'b1, "R5 flag survives write without start", int'(irq_o), 1);
    wr(2'd0, cw(1, 0, 1, 2'd2, 1, 0, 1));
    chk(irq_o == 1'b0, "R5 start write clears flag", int'(irq_o), 0);
    wr(2'd0, cw(0, 0, 1, 2'd2, 1, 0, 1));
    @(negedge clk);
    chk(sclk_o == 1'b0, "R2 clock low after abort", int'(sclk_o), 0);

    // data write while busy is ignored
    wr(2'd2, 8'h96);
    wr(2'd0, cw(1, 0, 0, 2'd0, 1, 1, 1));
    snap = rx_data_o;
    wr(2'd2, 8'h69);
    chk(rx_data_o == snap, "R12 data write ignored while busy", int'(rx_data_o), int'(snap));
    wr(2'd0, cw(0, 0, 0, 2'd0, 1, 1, 1));
    wr(2'd2, 8'h69);
    chk(rx_data_o == 8'h69, "R12 data write while idle", int'(rx_data_o), 8'h69);

    // slave transfers
    slave_xfer(1, 1, 2'b10, 8'hC3, 8'h5A);
    slave_xfer(0, 0, 2'b01, 8'h12, 8'hE7);
    for (int n = 0; n < 3; n++)
      slave_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'b10,
                 8'($urandom), 8'($urandom));

    // Start write in the completion cycle
    wr(2'd1, 8'd2);
    wr(2'd2, 8'h5A);
    wr(2'd0, cw(1, 0, 1, 2'd2, 0, 1, 1));
    rcount = 0; prev = 1'b0;
    for (int c = 0; c < 200 && rcount < 8; c++) begin
      @(negedge clk);
      if (sclk_o && !prev) rcount++;
      prev = sclk_o;
    end
    repeat (2) @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd0; wr_data = cw(1, 0, 1, 2'd2, 0, 1, 1);
    @(negedge clk); wr_en = 1'b0;
    chk(start_o == 1'b1, "R13 start write wins", int'(start_o), 1);
    chk(irq_o == 1'b0, "R13 flag stays clear", int'(irq_o), 0);
    chk(sclk_o == 1'b0, "R13 clock restarts low", int'(sclk_o), 0);
    for (int c = 0; c < 200 && start_o; c++) @(negedge clk);
    chk(irq_o == 1'b1, "R13 restarted transfer completes", int'(irq_o), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule